// File: doc/BRIEF.md
# A-Operand Block Broadcast Selector

This block sits in front of a matrix multiply array and rewrites a packed A operand of sixteen equal-width blocks. The blocks are split into groups of neighbours whose size is a power of two chosen at runtime by a broadcast-size input. Within every group, one member chosen by a block-identifier input is copied into all members of that group. The identifier is taken relative to the group, so the same member position is the source in every group.

The transform is registered. A new operand and its controls are captured on a clock edge where the valid input is high, and the rewritten operand appears one cycle later with its valid output raised. A broadcast size of zero leaves the operand unchanged. A size of four or more turns all sixteen blocks into copies of one block.

Top module: `ablk_bcast`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` becomes 0 and `a_out` becomes all zeros on that edge.
- R2: `out_valid` after a clock edge equals `in_valid` sampled at that edge.
- R3: With `bcast_size` = 0, a captured operand appears unchanged on `a_out`.
- R4: Block k occupies bits [k*BLK_W +: BLK_W]. With clamped size s (1 to 4), output block d is input block (d with its low s bits replaced by the low s bits of `src_id`). With s=1, blocks 0 and 1 are equal, blocks 2 and 3 are equal, and so on. With s=2 and `src_id`=1, block 1 feeds blocks 0 to 3 and block 5 feeds blocks 4 to 7.
- R5: Bits of `src_id` at positions s and above have no effect on `a_out`.
- R6: `bcast_size` values 5, 6 and 7 act exactly as 4: every output block is a copy of input block `src_id`.
- R7: On an edge where `in_valid` is low, `a_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| bcast_size | input | 3 | Group size exponent (group = 2^size blocks, clamped at 4) |
| src_id | input | 4 | Source member index within each group |
| a_in | input | 16*BLK_W | Packed A operand, block 0 in the low bits |
| out_valid | output | 1 | `a_out` holds a freshly transformed operand |
| a_out | output | 16*BLK_W | Rewritten A operand |

## Verification
The operand is filled with a distinct, recognisable value in every block, so that a wrong source index shows up as a wrong block rather than as an accidental match. Directed cases cover pass-through, pairs, the size-2 identifier-1 example, the single group of sixteen, and sizes 5 to 7. These tell apart a missing clamp from a correct one. Two identifiers that differ only in bits above the size are compared, to expose any use of the ignored bits. Random sizes, identifiers, data and gaps in `in_valid` then check the source index formula and the holding of the output register together.

// File: rtl/ablk_pkg.sv
package ablk_pkg;
    localparam int NBLK   = 16;
    localparam int IDX_W  = $clog2(NBLK);
    localparam int SZ_W   = 3;
    localparam int MAX_SZ = IDX_W;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [SZ_W-1:0]  size_t;

    typedef struct packed {
        size_t size;
        idx_t  ident;
    } ctrl_t;

    // Mask of the index bits that select a member inside a group.
    function automatic idx_t size_mask(size_t s);
        idx_t m;
        int   c;
        c = (int'(s) > MAX_SZ) ? MAX_SZ : int'(s);
        for (int b = 0; b < IDX_W; b++) begin
            m[b] = (b < c);
        end
        return m;
    endfunction

    // Source block for a destination: group base plus member index.
    function automatic idx_t src_of(idx_t dst, idx_t mask, idx_t id);
        return (dst & ~mask) | (id & mask);
    endfunction
endpackage

// File: rtl/ablk_ctrl.sv
module ablk_ctrl
    import ablk_pkg::*;
(
    input  ctrl_t ctrl,
    output idx_t  mask,
    output idx_t  ident
);
    always_comb begin
        mask  = size_mask(ctrl.size);
        ident = ctrl.ident & mask;
    end
endmodule

// File: rtl/ablk_lane.sv
module ablk_lane
    import ablk_pkg::*;
#(
    parameter int BLK_W = 32,
    parameter int DST   = 0
) (
    input  logic [NBLK*BLK_W-1:0] a_flat,
    input  idx_t                  mask,
    input  idx_t                  ident,
    output logic [BLK_W-1:0]      blk
);
    idx_t src;
    always_comb begin
        src = src_of(idx_t'(DST), mask, ident);
        blk = a_flat[src*BLK_W +: BLK_W];
    end
endmodule

// File: rtl/ablk_oreg.sv
module ablk_oreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         out_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) q <= d;
        end
    end
endmodule

// File: rtl/ablk_bcast.sv
module ablk_bcast
    import ablk_pkg::*;
#(
    parameter int BLK_W = 32,
    localparam int TOT_W = NBLK * BLK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SZ_W-1:0]  bcast_size,
    input  logic [IDX_W-1:0] src_id,
    input  logic [TOT_W-1:0] a_in,
    output logic             out_valid,
    output logic [TOT_W-1:0] a_out
);
    ctrl_t            ctrl;
    idx_t             mask;
    idx_t             ident;
    logic [TOT_W-1:0] routed;

    assign ctrl = '{size: bcast_size, ident: src_id};

    ablk_ctrl u_ctrl (
        .ctrl  (ctrl),
        .mask  (mask),
        .ident (ident)
    );

    for (genvar k = 0; k < NBLK; k++) begin : g_lane
        ablk_lane #(.BLK_W(BLK_W), .DST(k)) u_lane (
            .a_flat (a_in),
            .mask   (mask),
            .ident  (ident),
            .blk    (routed[k*BLK_W +: BLK_W])
        );
    end

    ablk_oreg #(.W(TOT_W)) u_oreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .d         (routed),
        .q         (a_out),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/ablk_bcast_chk.sv
module ablk_bcast_chk
    import ablk_pkg::*;
#(
    parameter int BLK_W = 32,
    localparam int TOT_W = NBLK * BLK_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [SZ_W-1:0]  bcast_size,
    input logic [TOT_W-1:0] a_in,
    input logic             out_valid,
    input logic [TOT_W-1:0] a_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && a_out == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bcast_size == '0) |=> (a_out == $past(a_in)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(a_out));

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        // R4
        pair_equal_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && bcast_size == 3'd1) |=>
            (a_out[k*BLK_W +: BLK_W] == a_out[(k^1)*BLK_W +: BLK_W]));

        // R6
        single_group_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && bcast_size >= 3'd4) |=>
            (a_out[k*BLK_W +: BLK_W] == a_out[BLK_W-1:0]));
    end
endmodule

bind ablk_bcast ablk_bcast_chk #(.BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .bcast_size (bcast_size),
    .a_in       (a_in),
    .out_valid  (out_valid),
    .a_out      (a_out)
);

// File: tb/ablk_bcast_test.sv
module ablk_bcast_test;
    localparam int CLK_P = 10;
    localparam int NB    = 16;
    localparam int BW    = 32;
    localparam int TW    = NB * BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [2:0]    bcast_size = '0;
    logic [3:0]    src_id = '0;
    logic [TW-1:0] a_in = '0;
    logic          out_valid;
    logic [TW-1:0] a_out;

    int checks = 0;
    int fails  = 0;

    ablk_bcast #(.BLK_W(BW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .bcast_size(bcast_size),
        .src_id(src_id), .a_in(a_in), .out_valid(out_valid), .a_out(a_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [TW-1:0] expect_out(logic [TW-1:0] a, logic [2:0] s, logic [3:0] id);
        logic [TW-1:0] r;
        int c, m, src;
        c = (s > 3'd4) ? 4 : int'(s);
        m = (1 << c) - 1;
        for (int d = 0; d < NB; d++) begin
            src = (d & ~m) | (int'(id) & m);
            r[d*BW +: BW] = a[src*BW +: BW];
        end
        return r;
    endfunction

    function automatic logic [TW-1:0] tagged_data(int seed);
        logic [TW-1:0] r;
        for (int k = 0; k < NB; k++) r[k*BW +: BW] = 32'hB000_0000 + (seed << 8) + k;
        return r;
    endfunction

    function automatic logic [TW-1:0] rand_data();
        logic [TW-1:0] r;
        for (int k = 0; k < NB; k++) r[k*BW +: BW] = $urandom;
        return r;
    endfunction

    task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, sample at next falling edge.
    task automatic apply(logic v, logic [2:0] s, logic [3:0] id, logic [TW-1:0] a);
        in_valid = v; bcast_size = s; src_id = id; a_in = a;
        @(negedge clk);
    endtask

    task automatic directed(string req, logic [2:0] s, logic [3:0] id, int seed);
        logic [TW-1:0] a;
        a = tagged_data(seed);
        apply(1'b1, s, id, a);
        check_bit(req, out_valid, 1'b1);
        check(req, a_out, expect_out(a, s, id));
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [TW-1:0] held, a, r1, r2;
        void'($urandom(32'd1234));
        @(negedge clk);
        apply(1'b1, 3'd2, 4'd1, tagged_data(1));
        // R1 reset state
        check_bit("R1", out_valid, 1'b0);
        check("R1", a_out, '0);
        rst = 1'b0;

        directed("R3", 3'd0, 4'd9, 2);
        directed("R4", 3'd1, 4'd0, 3);
        directed("R4", 3'd1, 4'd1, 4);
        directed("R4", 3'd2, 4'd1, 5);
        directed("R4", 3'd3, 4'd6, 6);
        directed("R4", 3'd4, 4'd15, 7);
        // R4 explicit example: block 5 feeds block 6 for s=2 id=1
        a = tagged_data(8);
        apply(1'b1, 3'd2, 4'd1, a);
        check("R4", {{(TW-BW){1'b0}}, a_out[6*BW +: BW]}, {{(TW-BW){1'b0}}, a[5*BW +: BW]});

        // R5 upper identifier bits ignored
        a = tagged_data(9);
        apply(1'b1, 3'd2, 4'b0001, a); r1 = a_out;
        apply(1'b1, 3'd2, 4'b1101, a); r2 = a_out;
        check("R5", r2, r1);
        apply(1'b1, 3'd1, 4'b1110, a);
        check("R5", a_out, expect_out(a, 3'd1, 4'b0000));

        // R6 clamp
        directed("R6", 3'd5, 4'd3, 10);
        directed("R6", 3'd7, 4'd12, 11);
        a = tagged_data(12);
        apply(1'b1, 3'd6, 4'd7, a);
        check("R6", a_out, expect_out(a, 3'd4, 4'd7));

        // R7 hold and R2 valid drop
        held = a_out;
        apply(1'b0, 3'd0, 4'd0, rand_data());
        check_bit("R2", out_valid, 1'b0);
        check("R7", a_out, held);
        apply(1'b0, 3'd3, 4'd5, rand_data());
        check("R7", a_out, held);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic v;
            logic [2:0] s;
            logic [3:0] id;
            v = ($urandom % 4) != 0;
            s = 3'($urandom);
            id = 4'($urandom);
            a = rand_data();
            if (v) held = expect_out(a, s, id);
            apply(v, s, id, a);
            check_bit("R2", out_valid, v);
            check(v ? "R4" : "R7", a_out, held);
        end

        // R1 reset after activity
        rst = 1'b1;
        apply(1'b1, 3'd1, 4'd1, rand_data());
        check_bit("R1", out_valid, 1'b0);
        check("R1", a_out, '0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule